// File: doc/BRIEF.md
# Square-Wave and Alarm-Interrupt Pin Controller

This block owns the control, status and trickle-charge configuration bits that decide what a single shared output pin carries. With interrupt mode off, the pin carries a square wave at one of four rates derived from a 32.768 kHz crystal. With interrupt mode on, it carries the alarm interrupt level. The block also keeps two sticky flags, oscillator-stopped and alarm-matched, which software can only clear, never set. It also checks the charger configuration byte against a fixed enable key and returns the charger settings in decoded form.

The crystal arrives as `osc_tick`, a one-cycle strobe in the system clock domain that fires at each half-period of the 32.768 kHz waveform, which is 65,536 times per second. A free-running divider counts these strobes, and the selected rate is taken from one of its bits. The pin value and its output-enable are active-high internal signals. The open-drain or tri-state stage lies outside the block. Registers sit at a 2-bit address: 0 holds control, 1 holds status and 2 holds the charger byte.

Top module: `sqwint_ctrl`

## Requirements
- R1: After reset, control reads 0x18, status reads 0x80 and the charger byte reads 0x00. Control bit 7 is oscillator-off-on-battery, bit 5 is battery output enable, bits 4:3 are the rate, bit 2 is interrupt mode and bit 0 is alarm interrupt enable. Status bit 7 is the oscillator-stop flag and bit 0 is the alarm flag.
- R2: With interrupt mode 0 and the oscillator running, the pin toggles after every 1, 4 or 8 ticks for rate 11, 10 or 01. For rate 00 it toggles after every 2^(CNT_W-1) ticks. The phase follows a tick counter that starts at zero at reset and wraps at 2^CNT_W.
- R3: With interrupt mode 0 and `osc_run` low, the pin is 0.
- R4: With interrupt mode 1, the pin and `irq_level` both equal alarm flag AND alarm interrupt enable.
- R5: An `alarm_hit` pulse sets the alarm flag whatever the interrupt mode and enable are. Writing 0 to status bit 0 clears the flag. Writing 1 to it leaves the flag unchanged.
- R6: The oscillator-stop flag sets on the cycle after `osc_run` falls from 1 to 0. Writing 0 to status bit 7 clears it. Writing 1 to it has no effect.
- R7: `pin_oe` is high when `supply_ok` is high or the battery output enable bit is 1. Otherwise it is low.
- R8: The charger is enabled only when byte bits 7:4 equal 1010, bits 3:2 are 01 (no diode) or 10 (one diode), and bits 1:0 are not 00. When disabled, `chg_diode` and `chg_res` read 0. When enabled, `chg_res` equals bits 1:0.
- R9: The charger byte reads back exactly as written. Control bits 6 and 1 and status bits 6:1 always read 0.
- R10: `osc_halt` is high exactly when the oscillator-off-on-battery bit is 1 and `supply_ok` is low.
- R11: Ticks that arrive while `osc_run` is low do not advance the divider.
- R12: When an `alarm_hit` and a write of 0 to the alarm flag land on the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 charger |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| osc_tick | input | 1 | Strobe at each half-period of the 32.768 kHz crystal |
| osc_run | input | 1 | High while the oscillator is running |
| supply_ok | input | 1 | High while main supply is in tolerance |
| alarm_hit | input | 1 | One-cycle alarm match pulse |
| pin_val | output | 1 | Value for the shared pin |
| pin_oe | output | 1 | Active-high enable for the shared pin |
| irq_level | output | 1 | Alarm interrupt level |
| osc_halt | output | 1 | Request to stop the oscillator while on battery |
| chg_en | output | 1 | Charger enabled |
| chg_diode | output | 1 | Series diode selected |
| chg_res | output | 2 | Resistor select, increasing resistance 1..3 |

## Verification
The scoreboard follows the divider phase across all four rates, including the slowest rate's wrap. A wrong tap or a divider that skipped ticks would drift away from the model within a few hundred ticks. Stopping the oscillator in the middle of a rate must freeze both the pin and the phase, so a divider that counted ticks while stopped resumes at the wrong phase. The status flags are written with 1s, with 0s, and with a clear in the same cycle as an alarm pulse: a design that lets writes set a flag, or lets the clear win, would leave the wrong status byte. The charger byte is checked with the key paired with each invalid diode and resistor code, where a decoder that looked at only one field would report an enabled charger.

// File: rtl/sqwint_pkg.sv
package sqwint_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_CHG  = 2'd2
   } reg_sel_e;

   typedef struct packed {
      logic       osc_off_bat;
      logic       bat_out_en;
      logic [1:0] rate;
      logic       int_mode;
      logic       alarm_ie;
   } ctrl_t;

   typedef struct packed {
      logic       en;
      logic       diode;
      logic [1:0] res;
   } chg_t;

   localparam logic [3:0] CHG_KEY    = 4'b1010;
   localparam logic [1:0] RATE_RESET = 2'b11;

endpackage

// File: rtl/sqwint_regs.sv
module sqwint_regs
   import sqwint_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              osc_run,
   input  logic              alarm_hit,
   output ctrl_t             ctrl,
   output logic              osf,
   output logic              af,
   output logic [DATA_W-1:0] chg_byte
);

   localparam int MSB = DATA_W - 1;

   if (DATA_W != 8) begin : g_bad_width
      $error("sqwint_regs: DATA_W must be 8");
   end

   logic run_q;
   logic wr_ctrl, wr_stat, wr_chg;

   assign wr_ctrl = reg_wr && (reg_addr == SEL_CTRL);
   assign wr_stat = reg_wr && (reg_addr == SEL_STAT);
   assign wr_chg  = reg_wr && (reg_addr == SEL_CHG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '{osc_off_bat: 1'b0, bat_out_en: 1'b0, rate: RATE_RESET,
                       int_mode: 1'b0, alarm_ie: 1'b0};
         chg_byte <= '0;
         run_q    <= 1'b0;
         osf      <= 1'b1;
         af       <= 1'b0;
      end else begin
         run_q <= osc_run;
         if (wr_ctrl) begin
            ctrl.osc_off_bat <= reg_wdata[7];
            ctrl.bat_out_en  <= reg_wdata[5];
            ctrl.rate        <= reg_wdata[4:3];
            ctrl.int_mode    <= reg_wdata[2];
            ctrl.alarm_ie    <= reg_wdata[0];
         end
         if (wr_chg)
            chg_byte <= reg_wdata;
         if (run_q && !osc_run)
            osf <= 1'b1;
         else if (wr_stat && !reg_wdata[MSB])
            osf <= 1'b0;
         if (alarm_hit)
            af <= 1'b1;
         else if (wr_stat && !reg_wdata[0])
            af <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         SEL_CTRL: reg_rdata = {ctrl.osc_off_bat, 1'b0, ctrl.bat_out_en,
                                ctrl.rate, ctrl.int_mode, 1'b0, ctrl.alarm_ie};
         SEL_STAT: reg_rdata = {osf, 6'b0, af};
         SEL_CHG:  reg_rdata = chg_byte;
         default:  reg_rdata = '0;
      endcase
   end

   // R6
   osf_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_run) |=> osf);

   // R5
   af_only_by_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(af) |-> $past(alarm_hit));

   // R12
   af_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |=> af);

endmodule

// File: rtl/sqwint_div.sv
module sqwint_div #(
   parameter int CNT_W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       run,
   input  logic [1:0] rate,
   output logic       sq
);

   localparam int TAP_FULL = 0;
   localparam int TAP_QTR  = 2;
   localparam int TAP_8TH  = 3;
   localparam int TAP_SLOW = CNT_W - 1;

   if (CNT_W < 5) begin : g_bad_cnt
      $error("sqwint_div: CNT_W must be at least 5");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (tick && run)
         cnt <= cnt + 1'b1;
   end

   always_comb begin
      unique case (rate)
         2'b11:   sq = cnt[TAP_FULL];
         2'b10:   sq = cnt[TAP_QTR];
         2'b01:   sq = cnt[TAP_8TH];
         default: sq = cnt[TAP_SLOW];
      endcase
   end

   // R11
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && run) |=> $stable(cnt));

endmodule

// File: rtl/sqwint_chg.sv
module sqwint_chg
   import sqwint_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] chg_byte,
   output chg_t              chg
);

   localparam int KEY_LO = DATA_W - 4;

   if (DATA_W != 8) begin : g_bad_width
      $error("sqwint_chg: DATA_W must be 8");
   end

   logic key_ok, diode_ok, res_ok;

   assign key_ok   = chg_byte[DATA_W-1:KEY_LO] == CHG_KEY;
   assign diode_ok = chg_byte[3:2] == 2'b01 || chg_byte[3:2] == 2'b10;
   assign res_ok   = chg_byte[1:0] != 2'b00;

   always_comb begin
      chg.en    = key_ok && diode_ok && res_ok;
      chg.diode = chg.en && chg_byte[3];
      chg.res   = chg.en ? chg_byte[1:0] : 2'b00;
   end

   always_comb begin
      // R8
      chg_off_clean_chk: assert (chg.en || (chg.res == 2'b00 && !chg.diode));
   end

endmodule

// File: rtl/sqwint_ctrl.sv
module sqwint_ctrl
   import sqwint_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 16,
   parameter bit REG_PIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              osc_tick,
   input  logic              osc_run,
   input  logic              supply_ok,
   input  logic              alarm_hit,
   output logic              pin_val,
   output logic              pin_oe,
   output logic              irq_level,
   output logic              osc_halt,
   output logic              chg_en,
   output logic              chg_diode,
   output logic [1:0]        chg_res
);

   ctrl_t             ctrl;
   chg_t              chg;
   logic              osf, af, sq, pin_next;
   logic [DATA_W-1:0] chg_byte;

   sqwint_regs #(.DATA_W(DATA_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .osc_run   (osc_run),
      .alarm_hit (alarm_hit),
      .ctrl      (ctrl),
      .osf       (osf),
      .af        (af),
      .chg_byte  (chg_byte)
   );

   sqwint_div #(.CNT_W(CNT_W)) div_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (osc_tick),
      .run   (osc_run),
      .rate  (ctrl.rate),
      .sq    (sq)
   );

   sqwint_chg #(.DATA_W(DATA_W)) chg_i (
      .chg_byte (chg_byte),
      .chg      (chg)
   );

   assign irq_level = af && ctrl.alarm_ie;
   assign pin_next  = ctrl.int_mode ? irq_level : (osc_run && sq);
   assign pin_oe    = supply_ok || ctrl.bat_out_en;
   assign osc_halt  = ctrl.osc_off_bat && !supply_ok;
   assign chg_en    = chg.en;
   assign chg_diode = chg.diode;
   assign chg_res   = chg.res;

   if (REG_PIN) begin : g_pin_flop
      logic pin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pin_q <= 1'b0;
         else
            pin_q <= pin_next;
      end
      assign pin_val = pin_q;
   end else begin : g_pin_comb
      assign pin_val = pin_next;

      // R4
      pin_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ctrl.int_mode |-> pin_val == irq_level);

      // R3
      pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!ctrl.int_mode && !osc_run) |-> !pin_val);
   end

   // R7
   oe_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe |-> !supply_ok);

   // R10
   halt_bat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      osc_halt |-> !pin_oe || ctrl.bat_out_en);

endmodule

// File: tb/sqwint_ctrl_tb_top.sv
module sqwint_ctrl_tb_top;

   localparam int CLK_P   = 10;
   localparam int CNT_W   = 8;
   localparam int K_RD    = 0;
   localparam int K_PIN   = 1;
   localparam int K_OE    = 2;
   localparam int K_CHG   = 3;
   localparam int K_HALT  = 4;
   localparam int K_IRQ   = 5;

   typedef struct {
      int         kind;
      logic [7:0] exp;
      string      tag;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       osc_tick = 1'b0, osc_run = 1'b1, supply_ok = 1'b1, alarm_hit = 1'b0;
   logic       pin_val, pin_oe, irq_level, osc_halt, chg_en, chg_diode;
   logic [1:0] chg_res;

   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 1'b0;
   item_t      q[$];
   logic [CNT_W-1:0] mcnt = '0;

   always #(CLK_P/2) clk = ~clk;

   sqwint_ctrl #(.CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .osc_tick(osc_tick),
      .osc_run(osc_run), .supply_ok(supply_ok), .alarm_hit(alarm_hit),
      .pin_val(pin_val), .pin_oe(pin_oe), .irq_level(irq_level),
      .osc_halt(osc_halt), .chg_en(chg_en), .chg_diode(chg_diode),
      .chg_res(chg_res)
   );

   // monitor: pops expected items and compares mid-cycle
   always @(negedge clk) begin
      while (q.size() > 0) begin
         item_t      it;
         logic [7:0] act;
         it = q.pop_front();
         case (it.kind)
            K_RD:    act = reg_rdata;
            K_PIN:   act = {7'd0, pin_val};
            K_OE:    act = {7'd0, pin_oe};
            K_CHG:   act = {4'd0, chg_en, chg_diode, chg_res};
            K_HALT:  act = {7'd0, osc_halt};
            default: act = {7'd0, irq_level};
         endcase
         n_chk++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_item(input int kind, input logic [7:0] exp, input string tag);
      item_t it;
      it.kind = kind;
      it.exp  = exp;
      it.tag  = tag;
      q.push_back(it);
      step();
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      step();
      reg_wr    = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
      reg_addr = a;
      expect_item(K_RD, exp, tag);
   endtask

   task automatic tick_once();
      osc_tick = 1'b1;
      step();
      osc_tick = 1'b0;
      if (osc_run)
         mcnt = mcnt + 1'b1;
   endtask

   function automatic logic [7:0] ctrl_b(input bit off, input bit bat,
                                         input logic [1:0] rate, input bit im, input bit ie);
      return {off, 1'b0, bat, rate, im, 1'b0, ie};
   endfunction

   function automatic logic sq_exp(input logic [1:0] rate);
      case (rate)
         2'b11:   return mcnt[0];
         2'b10:   return mcnt[2];
         2'b01:   return mcnt[3];
         default: return mcnt[CNT_W-1];
      endcase
   endfunction

   function automatic logic [7:0] chg_exp(input logic [7:0] b);
      logic en;
      en = (b[7:4] == 4'b1010) && (b[3:2] == 2'b01 || b[3:2] == 2'b10) && (b[1:0] != 2'b00);
      return {4'd0, en, en && b[3:2] == 2'b10, en ? b[1:0] : 2'b00};
   endfunction

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [7:0] pats[8] = '{8'hA5, 8'hA9, 8'hAA, 8'hA7, 8'hA1, 8'hAD, 8'hA4, 8'h55};
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      rd_chk(2'd0, 8'h18, "R1 ctrl");
      rd_chk(2'd1, 8'h80, "R1 status");
      rd_chk(2'd2, 8'h00, "R1 charger");
      expect_item(K_OE, 8'h01, "R1 oe");

      // R2 each rate, square wave follows tick phase
      for (int r = 3; r >= 0; r--) begin
         wr(2'd0, ctrl_b(0, 0, 2'(r), 0, 0));
         for (int t = 0; t < 300; t++) begin
            tick_once();
            expect_item(K_PIN, {7'd0, sq_exp(2'(r))}, "R2 rate");
         end
      end

      // R6 / R3 / R11 oscillator stop
      wr(2'd0, ctrl_b(0, 0, 2'b11, 0, 0));
      wr(2'd1, 8'h00);
      rd_chk(2'd1, 8'h00, "R6 osf cleared");
      if (mcnt[0] == 1'b0) tick_once();
      osc_run = 1'b0;
      step();
      rd_chk(2'd1, 8'h80, "R6 osf on stop");
      expect_item(K_PIN, 8'h00, "R3 pin quiet when stopped");
      for (int t = 0; t < 5; t++) tick_once();
      osc_run = 1'b1;
      expect_item(K_PIN, {7'd0, sq_exp(2'b11)}, "R11 phase held");
      wr(2'd1, 8'h80);
      rd_chk(2'd1, 8'h80, "R6 write 1 ignored");
      wr(2'd1, 8'h00);
      rd_chk(2'd1, 8'h00, "R6 write 0 clears");

      // R4 / R5 interrupt mode and alarm flag
      wr(2'd0, ctrl_b(0, 0, 2'b11, 1, 0));
      alarm_hit = 1'b1; step(); alarm_hit = 1'b0;
      rd_chk(2'd1, 8'h01, "R5 alarm sets flag");
      expect_item(K_PIN, 8'h00, "R4 pin masked by enable");
      wr(2'd0, ctrl_b(0, 0, 2'b11, 1, 1));
      expect_item(K_PIN, 8'h01, "R4 pin shows irq");
      expect_item(K_IRQ, 8'h01, "R4 irq level");
      wr(2'd1, 8'h01);
      rd_chk(2'd1, 8'h01, "R5 write 1 keeps flag");
      wr(2'd1, 8'h00);
      rd_chk(2'd1, 8'h00, "R5 write 0 clears");
      expect_item(K_PIN, 8'h00, "R4 pin drops");
      // R12 same-cycle set and clear
      reg_addr = 2'd1; reg_wdata = 8'h00; reg_wr = 1'b1; alarm_hit = 1'b1;
      step();
      reg_wr = 1'b0; alarm_hit = 1'b0;
      rd_chk(2'd1, 8'h01, "R12 set beats clear");
      wr(2'd1, 8'h00);
      wr(2'd0, ctrl_b(0, 0, 2'b11, 0, 0));
      alarm_hit = 1'b1; step(); alarm_hit = 1'b0;
      rd_chk(2'd1, 8'h01, "R5 flag set in square mode");
      wr(2'd1, 8'h00);

      // R7 / R10 supply and battery bits
      supply_ok = 1'b0;
      expect_item(K_OE, 8'h00, "R7 oe off on battery");
      wr(2'd0, ctrl_b(0, 1, 2'b11, 0, 0));
      expect_item(K_OE, 8'h01, "R7 battery enable keeps oe");
      expect_item(K_HALT, 8'h00, "R10 no halt");
      wr(2'd0, ctrl_b(1, 0, 2'b11, 0, 0));
      expect_item(K_HALT, 8'h01, "R10 halt on battery");
      supply_ok = 1'b1;
      expect_item(K_HALT, 8'h00, "R10 halt gone with supply");
      expect_item(K_OE, 8'h01, "R7 oe with supply");

      // R9 unused bits and readback
      wr(2'd0, 8'hFF);
      rd_chk(2'd0, 8'hBD, "R9 ctrl unused bits");
      wr(2'd1, 8'hFF);
      rd_chk(2'd1, 8'h00, "R9 status unused bits");

      // R8 / R9 charger key decode
      foreach (pats[i]) begin
         wr(2'd2, pats[i]);
         rd_chk(2'd2, pats[i], "R9 charger readback");
         expect_item(K_CHG, chg_exp(pats[i]), "R8 charger decode");
      end

      step();
      finish_run();
   end

endmodule